// File: doc/BRIEF.md
# Windowed 32-to-48-bit Address Remapper

This block sits on the address path of a processor whose master port is 32 bits wide. It lets that master reach a 48-bit physical space. A small bank of windows is programmed through a plain 32-bit register port. Each window has an enable, a size exponent, a 32-bit match base and a 48-bit replacement base. The replacement base is split into a low word and a separate 16-bit upper word.

Each request address is compared against every enabled window at once. On a hit, the address bits inside the window are kept and the bits above them are replaced from the replacement base. On a miss, the address leaves zero-extended. The result comes out one clock after the request, together with a hit flag and the index of the window that matched.

Top module: `xlat_unit`

## Requirements
- R1: After reset every window is disabled, so all control words read 0, no translation result is valid, and a request leaves untranslated with the hit flag low.
- R2: The windows are register groups at byte offset 0x40 + 0x10*k, for k from 0 to NUM_REGIONS-1. Within a group, +0x0 is control, +0x4 is match base, +0x8 is replacement base bits 31:0, and +0xC is replacement base bits 47:32 in its low 16 bits. In the control word, bit 31 is the enable and bits 5:0 are the size exponent. Control bits 30:6 and upper-word bits 31:16 read back as 0. Offsets outside the map read 0. Configuration changes only on a write, and a write takes effect at the next clock edge.
- R3: With effective exponent n, an address hits an enabled window when addr[31:n] equals match_base[31:n]. The result is {repl_base[47:n], addr[n-1:0]}.
- R4: A size exponent below 12 acts as 12, which gives a 4 KiB window. An exponent above 32 acts as 32, so the window covers the whole input space.
- R5: When no enabled window hits, the result is {16'h0, addr}, the hit flag is 0 and the region index is 0.
- R6: When several enabled windows hit, the lowest-numbered one is used.
- R7: A window with its enable bit clear never hits, whatever its other fields hold.
- R8: The result valid is high exactly one cycle after a request valid. The result address, hit flag and region index are registered one cycle after the request.
- R9: A request in the same cycle as a configuration write is translated with the configuration that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | 32 | Request address |
| rsp_valid_o | output | 1 | Translated address valid |
| rsp_addr_o | output | 48 | Translated address |
| rsp_hit_o | output | 1 | A window matched |
| rsp_region_o | output | $clog2(NUM_REGIONS) | Index of the matching window |

## Verification
A register write and a translation request can land on the same clock edge. The bench provokes this by writing to a window's control word to disable it while, in the same cycle, it presents an address that the window covers. It judges the response against the configuration that held before the write: a hit in that window with its replacement address. The very next request to the same address must then leave untranslated.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int IN_AW   = 32;
  localparam int OUT_AW  = 48;
  localparam int HI_W    = OUT_AW - IN_AW;
  localparam int SIZE_W  = 6;
  localparam int MIN_EXP = 12;
  localparam int MAX_EXP = 32;
  localparam int GRP_BASE   = 'h40;
  localparam int GRP_STRIDE = 'h10;

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size;
    logic [IN_AW-1:0]  match_base;
    logic [OUT_AW-1:0] repl_base;
  } win_cfg_t;

  function automatic logic [SIZE_W-1:0] eff_exp(input logic [SIZE_W-1:0] s);
    if (s < SIZE_W'(MIN_EXP)) return SIZE_W'(MIN_EXP);
    if (s > SIZE_W'(MAX_EXP)) return SIZE_W'(MAX_EXP);
    return s;
  endfunction
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
  import xlat_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int REG_AW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output win_cfg_t          cfg_o [NUM_REGIONS]
);
  localparam int SPAN  = NUM_REGIONS * GRP_STRIDE;
  localparam int GRP_W = REG_AW - 4;

  logic [31:0]       addr_ext;
  logic [REG_AW-1:0] rel;
  logic [GRP_W-1:0]  grp;
  logic [1:0]        word;
  logic              in_map;

  assign addr_ext = 32'(addr_i);
  assign in_map   = (addr_ext >= 32'(GRP_BASE)) && (addr_ext < 32'(GRP_BASE + SPAN));
  assign rel      = addr_i - REG_AW'(GRP_BASE);
  assign grp      = rel[REG_AW-1:4];
  assign word     = rel[3:2];

  win_cfg_t cfg_q [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
    logic sel;
    assign sel = wr_i && in_map && (grp == GRP_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[r] <= '0;
      end else if (sel) begin
        unique case (word)
          2'd0: begin
            cfg_q[r].en   <= wdata_i[31];
            cfg_q[r].size <= wdata_i[SIZE_W-1:0];
          end
          2'd1: cfg_q[r].match_base <= wdata_i;
          2'd2: cfg_q[r].repl_base[IN_AW-1:0] <= wdata_i;
          default: cfg_q[r].repl_base[OUT_AW-1:IN_AW] <= wdata_i[HI_W-1:0];
        endcase
      end
    end

    assign cfg_o[r] = cfg_q[r];

    // R2
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(cfg_q[r]));
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (in_map && grp == GRP_W'(r)) begin
        unique case (word)
          2'd0:    rdata_o = {cfg_q[r].en, {(31-SIZE_W){1'b0}}, cfg_q[r].size};
          2'd1:    rdata_o = cfg_q[r].match_base;
          2'd2:    rdata_o = cfg_q[r].repl_base[IN_AW-1:0];
          default: rdata_o = {{(32-HI_W){1'b0}}, cfg_q[r].repl_base[OUT_AW-1:IN_AW]};
        endcase
      end
    end
  end
endmodule

// File: rtl/xlat_window.sv
module xlat_window
  import xlat_pkg::*;
(
  input  win_cfg_t           cfg_i,
  input  logic [IN_AW-1:0]   addr_i,
  output logic               hit_o,
  output logic [OUT_AW-1:0]  xaddr_o
);
  logic [SIZE_W-1:0] n;
  logic [IN_AW:0]    span;
  logic [IN_AW-1:0]  keep;

  assign n    = eff_exp(cfg_i.size);
  assign span = ((IN_AW+1)'(1) << n) - (IN_AW+1)'(1);
  assign keep = span[IN_AW-1:0];

  assign hit_o   = cfg_i.en && (((addr_i ^ cfg_i.match_base) & ~keep) == '0);
  assign xaddr_o = {cfg_i.repl_base[OUT_AW-1:IN_AW],
                    (cfg_i.repl_base[IN_AW-1:0] & ~keep) | (addr_i & keep)};
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int REG_AW      = 8,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [IN_AW-1:0]  req_addr_i,
  output logic              rsp_valid_o,
  output logic [OUT_AW-1:0] rsp_addr_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_region_o
);
  win_cfg_t          cfg [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [OUT_AW-1:0] xaddr [NUM_REGIONS];

  xlat_regs #(.NUM_REGIONS(NUM_REGIONS), .REG_AW(REG_AW)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
    xlat_window i_win (
      .cfg_i   (cfg[r]),
      .addr_i  (req_addr_i),
      .hit_o   (hit_vec[r]),
      .xaddr_o (xaddr[r])
    );
  end

  logic              any_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [OUT_AW-1:0] sel_addr;

  // lowest index wins: scan from the top down
  always_comb begin
    any_hit  = 1'b0;
    sel_idx  = '0;
    sel_addr = {{HI_W{1'b0}}, req_addr_i};
    for (int r = NUM_REGIONS-1; r >= 0; r--) begin
      if (hit_vec[r]) begin
        any_hit  = 1'b1;
        sel_idx  = IDX_W'(r);
        sel_addr = xaddr[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_hit_o    <= 1'b0;
      rsp_region_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o   <= sel_addr;
        rsp_hit_o    <= any_hit;
        rsp_region_o <= sel_idx;
      end
    end
  end

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R8
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R5
  miss_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_vec == '0) |=>
      (rsp_addr_o == {{HI_W{1'b0}}, $past(req_addr_i)} && !rsp_hit_o));
  // R3
  hit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_vec != '0) |=>
      (rsp_hit_o && rsp_addr_o[MIN_EXP-1:0] == $past(req_addr_i[MIN_EXP-1:0])));
  // R6
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_vec[0]) |=> (rsp_region_o == '0));
endmodule

// File: tb/test_xlat_unit.sv
`timescale 1ns/1ps
module test_xlat_unit;
  localparam int NR = 8;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [47:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_region;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xlat_unit #(.NUM_REGIONS(NR), .REG_AW(AW)) i_xlat_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_hit_o(rsp_hit), .rsp_region_o(rsp_region)
  );

  // {addr[31:0], hit, region[2:0], result[47:0]}
  localparam logic [83:0] VEC [8] = '{
    {32'hD001_2345, 1'b1, 3'd0, 48'h004F_0201_2345},
    {32'hD008_0000, 1'b1, 3'd2, 48'h0001_AAA8_0000},
    {32'hD009_0000, 1'b1, 3'd2, 48'h0001_AAA9_0000},
    {32'hD010_0000, 1'b0, 3'd0, 48'h0000_D010_0000},
    {32'h1000_0FFF, 1'b1, 3'd1, 48'h1234_5555_5FFF},
    {32'h1000_1000, 1'b0, 3'd0, 48'h0000_1000_1000},
    {32'h0FFF_FFFF, 1'b0, 3'd0, 48'h0000_0FFF_FFFF},
    {32'h0000_1000, 1'b0, 3'd0, 48'h0000_0000_1000}
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic xlate(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd(8'h40, d); check("R1 ctrl0 after reset", 64'(d), 64'd0);
    rd(8'hB0, d); check("R1 ctrl7 after reset", 64'(d), 64'd0);
    xlate(32'hD001_2345);
    check("R1 passthrough addr", 64'(rsp_addr), 64'h0000_D001_2345);
    check("R1 hit low", 64'(rsp_hit), 64'd0);

    // program windows
    wr(8'h40, 32'h8000_0013); wr(8'h44, 32'hD000_0000);
    wr(8'h48, 32'h0200_0000); wr(8'h4C, 32'hABCD_004F);
    wr(8'h50, 32'h8FFF_FFC5); wr(8'h54, 32'h1000_0ABC);
    wr(8'h58, 32'h5555_5FFF); wr(8'h5C, 32'h0000_1234);
    wr(8'h60, 32'h8000_0014); wr(8'h64, 32'hD000_0000);
    wr(8'h68, 32'hAAA0_0000); wr(8'h6C, 32'h0000_0001);
    wr(8'h70, 32'h0000_0020); wr(8'h74, 32'h0000_0000);
    wr(8'h78, 32'h0000_0000); wr(8'h7C, 32'h0000_0099);

    // R2 readback and map
    rd(8'h50, d); check("R2 ctrl1 readback masks 30:6", 64'(d), 64'h8000_0005);
    rd(8'h4C, d); check("R2 upper word masks 31:16", 64'(d), 64'h0000_004F);
    rd(8'h44, d); check("R2 match base readback", 64'(d), 64'hD000_0000);
    rd(8'h68, d); check("R2 repl low readback", 64'(d), 64'hAAA0_0000);
    rd(8'h3C, d); check("R2 below map reads 0", 64'(d), 64'd0);
    rd(8'hC0, d); check("R2 above map reads 0", 64'(d), 64'd0);

    // R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < 8; i++) begin
      xlate(VEC[i][83:52]);
      check($sformatf("R8 valid entry %0d", i), 64'(rsp_valid), 64'd1);
      check($sformatf("R3 R5 R7 addr entry %0d", i), 64'(rsp_addr), 64'(VEC[i][47:0]));
      check($sformatf("R5 R6 hit entry %0d", i), 64'(rsp_hit), 64'(VEC[i][51]));
      check($sformatf("R6 region entry %0d", i), 64'(rsp_region), 64'(VEC[i][50:48]));
    end

    // R8 no request, no valid
    @(negedge clk);
    check("R8 idle valid low", 64'(rsp_valid), 64'd0);

    // R9 write and request in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h50; reg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 32'h1000_0FFF;
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0;
    check("R9 old config hit", 64'(rsp_hit), 64'd1);
    check("R9 old config region", 64'(rsp_region), 64'd1);
    check("R9 old config addr", 64'(rsp_addr), 64'h1234_5555_5FFF);
    xlate(32'h1000_0FFF);
    check("R9 R7 new config miss", 64'(rsp_addr), 64'h0000_1000_0FFF);
    check("R9 R7 new config hit low", 64'(rsp_hit), 64'd0);

    // R4 exponent above 32 covers all
    wr(8'hB0, 32'h8000_003F); wr(8'hB4, 32'h0000_0000);
    wr(8'hB8, 32'hFFFF_FFFF); wr(8'hBC, 32'h0000_00FF);
    rd(8'hB0, d); check("R2 ctrl7 readback", 64'(d), 64'h8000_003F);
    xlate(32'h1234_5678);
    check("R4 full window addr", 64'(rsp_addr), 64'h00FF_1234_5678);
    check("R4 full window region", 64'(rsp_region), 64'd7);
    xlate(32'hD001_2345);
    check("R6 lowest wins over 7", 64'(rsp_region), 64'd0);
    check("R6 lowest wins addr", 64'(rsp_addr), 64'h004F_0201_2345);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule